// File: doc/BRIEF.md
# Receive Byte Ring Buffer with Fill Counter and Threshold Interrupt

This block holds received bytes between a receive framer and a host read port. The framer hands over each decoded byte with a write strobe. The host takes bytes back with a read strobe and gets them in arrival order. A fill counter tells the host how many unread bytes are waiting. An interrupt pulse fires when that count climbs to a level picked by a two-bit code.

The storage is a 16-slot ring, so byte n and byte n+16 land in the same slot. If the host falls behind, writing does not stop. Each new byte replaces the oldest unread one, the count stays pinned at the depth, and a sticky flag records that data was lost. A synchronous clear input empties the ring, the counter and the flags. The surrounding register file pulses it whenever a control register is written during reception.

Top module: `rx_byte_ring`

## Requirements
- R1: While `rst_n` is low and right after it rises, `fill_level` is 0, `irq` is 0, `ovf_flag` is 0 and `rd_data` is 0.
- R2: A write strobe stores `wr_data` and raises `fill_level` by one. A read strobe with `fill_level` above 0 lowers it by one and puts the oldest stored byte on `rd_data` in the next cycle. Bytes come out in the order they were written.
- R3: A write while 16 bytes are stored and no read is taken discards the oldest byte and stores the new one. `fill_level` stays 16, and `ovf_flag` goes to 1 and stays there until a clear or a reset.
- R4: A write and a read in the same cycle with `fill_level` above 0 leave `fill_level` unchanged, and the read returns the oldest byte. This also holds when the ring is full, and `ovf_flag` is not set in that case.
- R5: A read with `fill_level` at 0 is ignored: `rd_data` keeps its value and `fill_level` stays 0. If a write comes in the same cycle, the write still counts (`fill_level` becomes 1).
- R6: `thr_sel` selects the interrupt level: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 12. `irq` is high for exactly one cycle, in the cycle after the write strobe that raises `fill_level` to that level.
- R7: `irq` stays 0 when `fill_level` reaches the level by decrementing or stays at it unchanged.
- R8: `clr` is synchronous and wins over any write or read in the same cycle. In the next cycle `fill_level`, `ovf_flag` and `irq` are 0 and `rd_data` is unchanged. Later reads return only bytes written after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of ring, counter and flags |
| wr_en | input | 1 | Byte write strobe from the framer |
| wr_data | input | DATA_W | Byte to store |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | DATA_W | Byte returned, valid the cycle after `rd_en` |
| thr_sel | input | 2 | Interrupt level code |
| fill_level | output | CNT_W (5) | Number of unread bytes, 0 to 16 |
| irq | output | 1 | One-cycle threshold pulse |
| ovf_flag | output | 1 | Sticky overwrite indicator |

## Verification
A framer write and a host read can land in the same cycle. The riskiest case is a full ring, where the write slot and the read slot are the same address, so the byte read out must be the old one while the counter and the overwrite flag stay where they are. The bench provokes this with directed full-ring cycles and with random traffic that keeps the ring near empty and near full. Each result is judged against a queue model that applies the read before the write and compares the byte, the count, the pulse and the flag every cycle. A clear in the same cycle as either strobe is also drawn at random, and the expected result is that the clear wins.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  // interrupt level for each select code
  function automatic int unsigned thr_level(input logic [1:0] code);
    case (code)
      2'd0:    thr_level = 1;
      2'd1:    thr_level = 4;
      2'd2:    thr_level = 8;
      default: thr_level = 12;
    endcase
  endfunction

  // ring pointer step with wrap at depth
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    ring_next = (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/rxb_ptr_ctrl.sv
module rxb_ptr_ctrl #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] fill,
  output logic             ovf,
  output logic             wr_go,
  output logic             rd_take,
  output logic             cnt_up
);
  import rxb_pkg::*;

  logic full, drop_old, cnt_dn;

  assign full     = (fill == CNT_W'(DEPTH));
  assign wr_go    = wr_en && !clr;
  assign rd_take  = rd_en && !clr && (fill != '0);
  assign drop_old = wr_go && full && !rd_take;
  assign cnt_up   = wr_go && !rd_take && !full;
  assign cnt_dn   = rd_take && !wr_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      ovf    <= 1'b0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      ovf    <= 1'b0;
    end else begin
      if (wr_go)
        wr_ptr <= PTR_W'(ring_next(int'(wr_ptr), DEPTH));
      if (rd_take || drop_old)
        rd_ptr <= PTR_W'(ring_next(int'(rd_ptr), DEPTH));
      if (cnt_up)
        fill <= fill + 1'b1;
      else if (cnt_dn)
        fill <= fill - 1'b1;
      if (drop_old)
        ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  // read captures the old slot content even when waddr == raddr
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (re)
      rdata <= mem[raddr];
  end

endmodule

// File: rtl/rxb_irq.sv
module rxb_irq #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cnt_up,
  input  logic [CNT_W-1:0] fill,
  input  logic [1:0]       thr_sel,
  output logic             irq,
  output logic             thr_hit
);
  import rxb_pkg::*;

  // only an increment that lands on the level counts
  assign thr_hit = cnt_up && ((int'(fill) + 1) == int'(thr_level(thr_sel)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq <= 1'b0;
    else if (clr)
      irq <= 1'b0;
    else
      irq <= thr_hit;
  end

endmodule

// File: rtl/rx_byte_ring.sv
module rx_byte_ring #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        thr_sel,
  output logic [CNT_W-1:0]  fill_level,
  output logic              irq,
  output logic              ovf_flag
);

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             wr_go, rd_take, cnt_up, thr_hit;

  rxb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .fill    (fill_level),
    .ovf     (ovf_flag),
    .wr_go   (wr_go),
    .rd_take (rd_take),
    .cnt_up  (cnt_up)
  );

  rxb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_go),
    .waddr (wr_ptr),
    .wdata (wr_data),
    .re    (rd_take),
    .raddr (rd_ptr),
    .rdata (rd_data)
  );

  rxb_irq #(.DEPTH(DEPTH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .cnt_up  (cnt_up),
    .fill    (fill_level),
    .thr_sel (thr_sel),
    .irq     (irq),
    .thr_hit (thr_hit)
  );

endmodule

// File: rtl/rxb_chk.sv
module rxb_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [CNT_W-1:0]  fill_level,
  input logic              irq,
  input logic              ovf_flag,
  input logic              cnt_up,
  input logic              thr_hit
);

  p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= CNT_W'(DEPTH));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == CNT_W'(DEPTH) && wr_en && !rd_en && !clr) |=> (fill_level == CNT_W'(DEPTH) && ovf_flag));

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr) |=> ovf_flag);

  p_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && !clr && fill_level != '0) |=> $stable(fill_level));

  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == '0 && rd_en && !wr_en && !clr) |=> (fill_level == '0 && $stable(rd_data)));

  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (fill_level == $past(fill_level) + 1'b1 && $past(cnt_up)));

  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_no_irq_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!thr_hit) |=> !irq);

  p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fill_level == '0 && !ovf_flag && !irq && $stable(rd_data)));

endmodule

bind rx_byte_ring rxb_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .fill_level (fill_level),
  .irq        (irq),
  .ovf_flag   (ovf_flag),
  .cnt_up     (cnt_up),
  .thr_hit    (thr_hit)
);

// File: tb/rx_byte_ring_tb.sv
module rx_byte_ring_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int DEP = 16;

  logic          clk = 1'b0;
  logic          rst_n, clr, wr_en, rd_en;
  logic [DW-1:0] wr_data, rd_data;
  logic [1:0]    thr_sel;
  logic [4:0]    fill_level;
  logic          irq, ovf_flag;

  int n_vec = 0;
  int n_bad = 0;

  logic [DW-1:0] mq[$];
  logic [DW-1:0] e_rd;
  logic          e_irq, e_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_byte_ring u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .thr_sel(thr_sel),
    .fill_level(fill_level), .irq(irq), .ovf_flag(ovf_flag)
  );

  // level per select code, stated differently from the design
  function automatic int lvl(input logic [1:0] s);
    return (s == 2'd0) ? 1 : 4 * int'(s);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, update model, compare at next negedge
  task automatic cyc(input bit w, input logic [DW-1:0] d, input bit r, input bit c,
                     input logic [1:0] s, input string tag);
    int old;
    wr_en = w; wr_data = d; rd_en = r; clr = c; thr_sel = s;
    if (c) begin
      mq.delete(); e_ovf = 1'b0; e_irq = 1'b0;
    end else begin
      old = mq.size();
      if (r && old > 0) e_rd = mq.pop_front();
      if (w) begin
        if (mq.size() == DEP) begin void'(mq.pop_front()); e_ovf = 1'b1; end
        mq.push_back(d);
      end
      e_irq = (mq.size() > old) && (mq.size() == lvl(s));
    end
    @(negedge clk);
    chk(tag, "fill_level", int'(fill_level), mq.size());
    chk(tag, "irq", int'(irq), int'(e_irq));
    chk(tag, "ovf_flag", int'(ovf_flag), int'(e_ovf));
    chk(tag, "rd_data", int'(rd_data), int'(e_rd));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5171));
    rst_n = 1'b0; clr = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0; thr_sel = 2'd1;
    e_rd = '0; e_irq = 1'b0; e_ovf = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1", "fill_level", int'(fill_level), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "ovf_flag", int'(ovf_flag), 0);
    chk("R1", "rd_data", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "fill_level after release", int'(fill_level), 0);

    // R6 level 4 reached by writes
    for (int i = 0; i < 4; i++) cyc(1, 8'hA0 + 8'(i), 0, 0, 2'd1, "R6");
    cyc(1, 8'hA4, 0, 0, 2'd1, "R2");
    // R7 down from 5 to 4 gives no pulse
    cyc(0, 8'h00, 1, 0, 2'd1, "R7");
    cyc(0, 8'h00, 0, 0, 2'd1, "R7");
    for (int i = 0; i < 4; i++) cyc(0, 8'h00, 1, 0, 2'd1, "R2");
    // R5 empty reads
    cyc(0, 8'h00, 1, 0, 2'd1, "R5");
    cyc(1, 8'h5E, 1, 0, 2'd1, "R5");
    cyc(0, 8'h00, 1, 0, 2'd1, "R5");
    // R3 overflow
    cyc(0, 8'h00, 0, 1, 2'd3, "R8");
    for (int i = 0; i < 20; i++) cyc(1, 8'h10 + 8'(i), 0, 0, 2'd3, "R3");
    // R4 full ring, write and read together
    cyc(1, 8'hEE, 1, 0, 2'd3, "R4");
    cyc(1, 8'hEF, 1, 0, 2'd3, "R4");
    for (int i = 0; i < 16; i++) cyc(0, 8'h00, 1, 0, 2'd3, "R3");
    // R4 partial fill
    for (int i = 0; i < 3; i++) cyc(1, 8'h30 + 8'(i), 0, 0, 2'd3, "R2");
    cyc(1, 8'h77, 1, 0, 2'd3, "R4");
    // R8 clear wins over write
    cyc(1, 8'h99, 1, 1, 2'd3, "R8");
    cyc(1, 8'h41, 0, 0, 2'd3, "R8");
    cyc(0, 8'h00, 1, 0, 2'd3, "R8");
    // R6 each select code
    for (int s = 0; s < 4; s++) begin
      cyc(0, 8'h00, 0, 1, 2'(s), "R8");
      for (int i = 0; i < 13; i++) cyc(1, 8'(i), 0, 0, 2'(s), "R6");
    end
    cyc(0, 8'h00, 0, 1, 2'd2, "R8");

    // random traffic
    begin
      logic [1:0] s = 2'd2;
      for (int k = 0; k < 5000; k++) begin
        bit w, r, c;
        if ($urandom_range(99) < 3) s = 2'($urandom_range(3));
        w = ($urandom_range(99) < ((k / 500) % 2 == 0 ? 60 : 40));
        r = ($urandom_range(99) < ((k / 500) % 2 == 0 ? 40 : 60));
        c = ($urandom_range(199) == 0);
        cyc(w, 8'($urandom), r, c, s, "R2");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule